// File: doc/BRIEF.md
# If-Then Predication Window Sequencer

This block keeps the state of a short predicated run of instructions in a compact instruction stream. An If-Then instruction hands it a 4-bit base condition and a 4-bit mask. Each instruction that follows in the run gets an execute-or-suppress decision. The decision comes from that slot's condition tested against the N, Z, C and V flags. The mask decides how many slots the run holds and whether each later slot takes the "then" or the "else" sense of the base condition.

The issue stage pulses `it_load` when it decodes an If-Then instruction. It pulses `advance` once for every instruction that then passes the predication point. In the cycle of the advance it reads `exec_en` to decide whether that instruction takes effect. `exec_en` is combinational from the stored state and the flag inputs. `in_block` is registered and reports whether a run is still open.

Top module: `itpred_seq`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `in_block` is 0 and `exec_en` is 1 for any flag values.
- R2: A load whose mask is 0000 leaves the sequencer idle. If a run was open, that run is closed.
- R3: The first advance after a load is decided against the base condition unchanged. The mask is not shifted on that slot.
- R4: On each later advance, the slot condition is the stored condition with bit 0 replaced by mask bit 3. The mask then shifts left by one place and bit 0 is filled with 0. The rewritten condition is kept for the next slot.
- R5: When the mask equals 1000 on an advance (after the shift, on later slots), the mask is cleared and `in_block` is 0 from the next cycle.
- R6: While the stored mask is 0, `in_block` is 0 and `exec_en` is 1 whatever the flags.
- R7: Condition codes, flags given as N, Z, C, V: 0000 Z; 0001 !Z; 0010 C; 0011 !C; 0100 N; 0101 !N; 0110 V; 0111 !V; 1000 C&!Z; 1001 !C|Z; 1010 N==V; 1011 N!=V; 1100 !Z&(N==V); 1101 Z|(N!=V); 1110 true.
- R8: Condition code 1111 evaluates to false, both when loaded directly and when produced by the bit-0 rewrite of 1110.
- R9: A load replaces any open run and restarts at the first slot. An `advance` in the same cycle as a load is ignored.
- R10: In a cycle without a load or an advance, the mask, the condition and the first-slot state are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| it_load | input | 1 | Strobe: an If-Then instruction was decoded |
| it_cond | input | 4 | Base condition carried by the If-Then instruction |
| it_mask | input | MASK_W | Mask carried by the If-Then instruction |
| advance | input | 1 | Strobe: one instruction passes the predication point |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| exec_en | output | 1 | Current instruction may take effect |
| in_block | output | 1 | A predication run is open (stored mask nonzero) |

## Verification
The bench walks runs of one to four slots with mixed then/else masks. A design that rewrote bit 0 on the first slot, or that did not keep the rewritten condition, would give the wrong sense on slot one or slot three. A base of 1110 with an else slot must produce the never-true code 1111; a design that treats 1111 as "always" would let that slot execute. An all-zero load in the middle of a run must close the run. A load in the same cycle as an advance must not use up the first slot. A slip in either of these shows as `in_block` staying or dropping a cycle off. Every condition code is swept against all sixteen flag combinations, measured against a separate per-code truth table.

// File: rtl/itpred_pkg.sv
package itpred_pkg;

  localparam int COND_W = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Base test picked by the upper three bits; bit 0 inverts it.
  // Code 1110 is always, code 1111 is never.
  function automatic logic cond_holds(input logic [COND_W-1:0] code,
                                      input flags_t f);
    logic base;
    unique case (code[3:1])
      3'd0: base = f.z;
      3'd1: base = f.c;
      3'd2: base = f.n;
      3'd3: base = f.v;
      3'd4: base = f.c & ~f.z;
      3'd5: base = (f.n == f.v);
      3'd6: base = ~f.z & (f.n == f.v);
      default: base = 1'b1;
    endcase
    if (code == 4'hF)           return 1'b0;
    else if (code[3:1] == 3'd7) return 1'b1;
    else                        return base ^ code[0];
  endfunction

endpackage

// File: rtl/itpred_cond_eval.sv
module itpred_cond_eval
  import itpred_pkg::*;
(
  input  logic [COND_W-1:0] code,
  input  flags_t            flags,
  output logic              pass
);
  always_comb pass = cond_holds(code, flags);
endmodule

// File: rtl/itpred_window.sv
module itpred_window
  import itpred_pkg::*;
#(
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [COND_W-1:0] load_cond,
  input  logic [MASK_W-1:0] load_mask,
  input  logic              advance,
  output logic [MASK_W-1:0] mask_q,
  output logic              first_q,
  output logic [COND_W-1:0] slot_cond
);
  localparam logic [MASK_W-1:0] LAST_PAT = {1'b1, {(MASK_W-1){1'b0}}};

  logic [COND_W-1:0] cond_q;
  logic [MASK_W-1:0] shifted;
  logic [MASK_W-1:0] mask_after;
  logic              step;

  // Condition used for the slot now at the predication point.
  always_comb begin
    if (first_q) slot_cond = cond_q;
    else         slot_cond = {cond_q[COND_W-1:1], mask_q[MASK_W-1]};
  end

  always_comb begin
    shifted    = first_q ? mask_q : {mask_q[MASK_W-2:0], 1'b0};
    mask_after = (shifted == LAST_PAT) ? '0 : shifted;
    step       = advance && (mask_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      cond_q  <= '0;
      first_q <= 1'b0;
    end else if (load) begin
      mask_q  <= load_mask;
      cond_q  <= load_cond;
      first_q <= (load_mask != '0);
    end else if (step) begin
      mask_q  <= mask_after;
      cond_q  <= slot_cond;
      first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/itpred_seq.sv
module itpred_seq
  import itpred_pkg::*;
#(
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              it_load,
  input  logic [3:0]        it_cond,
  input  logic [MASK_W-1:0] it_mask,
  input  logic              advance,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_v,
  output logic              exec_en,
  output logic              in_block
);
  logic [MASK_W-1:0] mask_q;
  logic              first_q;
  logic [COND_W-1:0] slot_cond;
  logic              cond_pass;
  flags_t            flags;

  assign flags = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

  itpred_window #(.MASK_W(MASK_W)) u_window (
    .clk       (clk),
    .rst       (rst),
    .load      (it_load),
    .load_cond (it_cond),
    .load_mask (it_mask),
    .advance   (advance),
    .mask_q    (mask_q),
    .first_q   (first_q),
    .slot_cond (slot_cond)
  );

  itpred_cond_eval u_eval (
    .code  (slot_cond),
    .flags (flags),
    .pass  (cond_pass)
  );

  assign in_block = (mask_q != '0);
  assign exec_en  = !in_block || cond_pass;
endmodule

// File: rtl/itpred_seq_chk.sv
module itpred_seq_chk #(
  parameter int MASK_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              it_load,
  input logic [3:0]        it_cond,
  input logic [MASK_W-1:0] it_mask,
  input logic              advance,
  input logic              exec_en,
  input logic              in_block,
  input logic [MASK_W-1:0] mask_q,
  input logic              first_q,
  input logic [3:0]        slot_cond
);
  localparam logic [MASK_W-1:0] LAST_PAT = {1'b1, {(MASK_W-1){1'b0}}};

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !in_block);

  p_zero_load_r2: assert property (@(posedge clk) disable iff (rst)
    it_load && it_mask == '0 |=> !in_block);

  p_first_slot_r3: assert property (@(posedge clk) disable iff (rst)
    it_load && it_mask != '0 |=> first_q && slot_cond == $past(it_cond));

  p_rewrite_r4: assert property (@(posedge clk) disable iff (rst)
    in_block && advance && !it_load && !first_q
    |=> !in_block || slot_cond[0] == $past(mask_q[MASK_W-2]));

  p_close_r5: assert property (@(posedge clk) disable iff (rst)
    in_block && advance && !it_load && first_q && mask_q == LAST_PAT |=> !in_block);

  p_idle_allows_r6: assert property (@(posedge clk) disable iff (rst)
    !in_block |-> exec_en);

  p_never_r8: assert property (@(posedge clk) disable iff (rst)
    in_block && slot_cond == 4'hF |-> !exec_en);

  p_load_opens_r9: assert property (@(posedge clk) disable iff (rst)
    it_load && it_mask != '0 |=> in_block);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !it_load && !advance |=> $stable(mask_q) && $stable(first_q) && $stable(slot_cond));
endmodule

bind itpred_seq itpred_seq_chk #(.MASK_W(MASK_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .it_load   (it_load),
  .it_cond   (it_cond),
  .it_mask   (it_mask),
  .advance   (advance),
  .exec_en   (exec_en),
  .in_block  (in_block),
  .mask_q    (mask_q),
  .first_q   (first_q),
  .slot_cond (slot_cond)
);

// File: tb/itpred_seq_tb.sv
module itpred_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       it_load;
  logic [3:0] it_cond;
  logic [3:0] it_mask;
  logic       advance;
  logic       flag_n, flag_z, flag_c, flag_v;
  logic       exec_en, in_block;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  itpred_seq #(.MASK_W(4)) dut_i (
    .clk(clk), .rst(rst), .it_load(it_load), .it_cond(it_cond),
    .it_mask(it_mask), .advance(advance), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .exec_en(exec_en), .in_block(in_block)
  );

  // Per-code truth table, flags as {N,Z,C,V}.
  function automatic logic ref_cond(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'h0: return z;        4'h1: return !z;
      4'h2: return cy;       4'h3: return !cy;
      4'h4: return n;        4'h5: return !n;
      4'h6: return v;        4'h7: return !v;
      4'h8: return cy && !z; 4'h9: return !cy || z;
      4'hA: return n == v;   4'hB: return n != v;
      4'hC: return !z && n == v;
      4'hD: return z || n != v;
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // {load, cond, mask, adv, nzcv, chk_en, exp_en, exp_blk_after}
  localparam int NV = 28;
  localparam logic [16:0] VECS [NV] = '{
    {1'b1,4'h0,4'b0100,1'b0,4'b0000,1'b0,1'b0,1'b1},  // EQ, two slots
    {1'b0,4'h0,4'b0000,1'b1,4'b0100,1'b1,1'b1,1'b1},  // R3 base EQ
    {1'b0,4'h0,4'b0000,1'b1,4'b0000,1'b1,1'b0,1'b0},  // R4/R5 EQ, closes
    {1'b0,4'h0,4'b0000,1'b1,4'b0000,1'b1,1'b1,1'b0},  // R6 idle
    {1'b1,4'hA,4'b1010,1'b0,4'b0000,1'b0,1'b0,1'b1},  // GE, three slots
    {1'b0,4'h0,4'b0000,1'b1,4'b1000,1'b1,1'b0,1'b1},  // R3 GE false
    {1'b0,4'h0,4'b0000,1'b1,4'b1000,1'b1,1'b1,1'b1},  // R4 LT true
    {1'b0,4'h0,4'b0000,1'b1,4'b1001,1'b1,1'b1,1'b0},  // R4 GE, closes
    {1'b1,4'hE,4'b1000,1'b0,4'b0000,1'b0,1'b0,1'b1},  // AL single slot
    {1'b0,4'h0,4'b0000,1'b1,4'b0000,1'b1,1'b1,1'b0},  // R5 first-slot close
    {1'b1,4'hE,4'b1100,1'b0,4'b0000,1'b0,1'b0,1'b1},  // AL then else
    {1'b0,4'h0,4'b0000,1'b1,4'b0000,1'b1,1'b1,1'b1},
    {1'b0,4'h0,4'b0000,1'b1,4'b0000,1'b1,1'b0,1'b0},  // R8 rewrite to 1111
    {1'b1,4'h8,4'b0001,1'b0,4'b0000,1'b0,1'b0,1'b1},  // HI, four slots
    {1'b0,4'h0,4'b0000,1'b1,4'b0010,1'b1,1'b1,1'b1},
    {1'b0,4'h0,4'b0000,1'b1,4'b0010,1'b1,1'b1,1'b1},  // R4 still HI
    {1'b1,4'h5,4'b0000,1'b0,4'b0000,1'b0,1'b0,1'b0},  // R2 hint closes run
    {1'b0,4'h0,4'b0000,1'b1,4'b0000,1'b1,1'b1,1'b0},  // R2/R6 idle
    {1'b1,4'h0,4'b0010,1'b0,4'b0000,1'b0,1'b0,1'b1},
    {1'b0,4'h0,4'b0000,1'b1,4'b0000,1'b1,1'b0,1'b1},
    {1'b1,4'h1,4'b1000,1'b0,4'b0000,1'b0,1'b0,1'b1},  // R9 override
    {1'b0,4'h0,4'b0000,1'b1,4'b0100,1'b1,1'b0,1'b0},  // R9 NE first slot
    {1'b1,4'h4,4'b1000,1'b1,4'b0000,1'b0,1'b0,1'b1},  // R9 adv ignored
    {1'b0,4'h0,4'b0000,1'b1,4'b1000,1'b1,1'b1,1'b0},  // R9 MI slot still there
    {1'b1,4'h0,4'b0100,1'b0,4'b0000,1'b0,1'b0,1'b1},
    {1'b0,4'h0,4'b0000,1'b0,4'b0000,1'b1,1'b0,1'b1},  // R10 no advance
    {1'b0,4'h0,4'b0000,1'b1,4'b0100,1'b1,1'b1,1'b1},  // R10 first slot kept
    {1'b0,4'h0,4'b0000,1'b1,4'b0100,1'b1,1'b1,1'b0}
  };

  task automatic drive(input logic ld, input logic [3:0] c, input logic [3:0] m,
                       input logic adv, input logic [3:0] f);
    it_load = ld; it_cond = c; it_mask = m; advance = adv;
    {flag_n, flag_z, flag_c, flag_v} = f;
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, 4'h0, 4'h0, 1'b0, 4'b0000);
    repeat (2) @(posedge clk);
    #1;
    check("R1 in_block after reset", in_block, 1'b0);
    check("R1 exec_en after reset", exec_en, 1'b1);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i][16], VECS[i][15:12], VECS[i][11:8], VECS[i][7], VECS[i][6:3]);
      #1;
      if (VECS[i][2]) check($sformatf("R3/R4 exec_en vec %0d", i), exec_en, VECS[i][1]);
      @(posedge clk);
      #1;
      check($sformatf("R5/R9 in_block vec %0d", i), in_block, VECS[i][0]);
    end

    // R7 / R8: every code against every flag set, on a single-slot run
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      drive(1'b1, c[3:0], 4'b1000, 1'b0, 4'b0000);
      @(negedge clk);
      for (int f = 0; f < 16; f++) begin
        drive(1'b0, 4'h0, 4'h0, 1'b0, f[3:0]);
        #1;
        check($sformatf("R7/R8 code %0h flags %0h", c, f), exec_en,
              ref_cond(c[3:0], f[3:0]));
        #1;
      end
      @(negedge clk);
      drive(1'b0, 4'h0, 4'h0, 1'b1, 4'b0000);
      @(posedge clk);
      #1;
      check("R5 single slot closes", in_block, 1'b0);
    end

    // R1: reset in the middle of an open run
    @(negedge clk);
    drive(1'b1, 4'h0, 4'b0001, 1'b0, 4'b0000);
    @(negedge clk);
    drive(1'b0, 4'h0, 4'h0, 1'b0, 4'b0000);
    #1;
    check("R1 run open before reset", in_block, 1'b1);
    check("R1 EQ fails before reset", exec_en, 1'b0);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset clears run", in_block, 1'b0);
    check("R1/R6 exec_en after reset", exec_en, 1'b1);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule